// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller is the power-mode state machine of a small microcontroller. Software asks for a low-power mode by pulsing a write strobe with a four-bit request field. The controller then halts the core, gates the core and peripheral clocks, and drops the oscillator enable, the power-net enable and the retention enable in the pattern that the chosen mode needs. It returns to normal running when an event that qualifies for that mode arrives. Each mode has its own set of wake events. The deepest mode can only be left through reset.

Five resting modes exist: run, idle, suspend, stop and sleep. A sixth, transient wake-up state holds the oscillator on and the clocks gated until an oscillator-ready handshake arrives. Suspend may only be entered while the system clock comes from one of the two internal oscillators. A request made under any other clock source is dropped and a sticky error output is raised. The comparator wake input is asynchronous, so it passes through a synchronizer, and only its rising edge counts as an event. All control pins are plain level signals with no handshake. The only handshake is the oscillator-ready input.

Top module: `pmu_seq_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) and after its release, the controller is in run mode (`mode` = 0), all enables are as in R2 for run, and `clk_err` is 0.
- R2: The outputs follow the current mode, written as {core_halt, core_clk_en, periph_clk_en, osc_en, pwr_en, ret_en}. Run (code 0) gives 011110. Idle (1) gives 101110. Suspend (2) gives 100010. Stop (3) gives 100001. Sleep (4) gives 100001. Wake-up (5) gives 100110.
- R3: A request is taken only in run mode, on a clock edge where `req_we` is high. The request bits are bit 3 stop, bit 2 sleep, bit 1 suspend and bit 0 idle. The highest set bit wins, and the new mode shows after that edge. A zero field, or a request made outside run mode, has no effect.
- R4: In idle, `irq_pend` high at a clock edge returns the controller to run at that edge. The other wake lines and the comparator have no effect in idle.
- R5: A suspend request that wins priority while `clk_src` is 2 or 3 is ignored, and `clk_err` is set and held until reset. Codes 0 (fast internal) and 1 (low-power internal) permit suspend.
- R6: In suspend, any of `wk_rtc_alarm`, `wk_rtc_fail`, `wk_touch`, `wk_port` or a comparator rise moves the controller to wake-up. `irq_pend` alone has no effect.
- R7: In sleep, the same events as in R6 wake the controller, except `wk_touch`, which has no effect.
- R8: In stop, no wake line, no comparator activity and no request leaves the mode. Only `rst_n` does.
- R9: `cmp0_in` passes through a two-flop synchronizer. A low-to-high change that is set up before clock edge k is seen by the mode logic at edge k+2. A level that is already high, or that stays high, never wakes the controller.
- R10: In wake-up, the controller stays with the clocks gated and `osc_en` high until `osc_ready` is high at a clock edge, and then it enters run at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only exit from stop |
| req_we | input | 1 | Write strobe for the mode request |
| req_bits | input | 4 | Request field: [3] stop, [2] sleep, [1] suspend, [0] idle |
| clk_src | input | 2 | Current system clock source: 0 fast internal, 1 low-power internal, 2 low-frequency, 3 external |
| irq_pend | input | 1 | Any interrupt pending |
| wk_rtc_alarm | input | 1 | Real-time clock alarm event |
| wk_rtc_fail | input | 1 | Real-time clock oscillator failure event |
| wk_touch | input | 1 | Capacitive-sense interrupt |
| wk_port | input | 1 | Port pin match event |
| cmp0_in | input | 1 | Asynchronous comparator 0 output |
| osc_ready | input | 1 | Oscillator started and stable |
| mode | output | 3 | Current mode code (see R2) |
| core_halt | output | 1 | Core execution halted |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Digital peripheral clock gate enable |
| osc_en | output | 1 | Internal oscillator enable |
| pwr_en | output | 1 | Switched power-net enable |
| ret_en | output | 1 | State retention enable |
| clk_err | output | 1 | Sticky: suspend requested under a forbidden clock source |

## Verification
A corrupted mode register shows up on `mode` and on the six enable pins one edge after the faulty transition. Comparing every enable on every cycle therefore catches a wrong state within one cycle. A wake set that has been mixed up between modes, or a wrong priority order, leaves the controller in the wrong mode at the very next edge. Those faults are exposed by sending each wake line alone into each mode. A synchronizer that is too short or too long moves the comparator wake by one cycle, and a cycle-exact model of R9 catches that shift.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_IDLE  = 3'd1,
    PM_SUSP  = 3'd2,
    PM_STOP  = 3'd3,
    PM_SLEEP = 3'd4,
    PM_WAKE  = 3'd5
  } pmu_mode_e;

  typedef struct packed {
    logic core_halt;
    logic core_clk_en;
    logic periph_clk_en;
    logic osc_en;
    logic pwr_en;
    logic ret_en;
  } pmu_ctl_t;

  // request field bit positions
  localparam int unsigned REQ_IDLE  = 0;
  localparam int unsigned REQ_SUSP  = 1;
  localparam int unsigned REQ_SLEEP = 2;
  localparam int unsigned REQ_STOP  = 3;
  localparam int unsigned REQ_W     = 4;

  // clock sources that allow suspend
  localparam logic [1:0] SRC_FAST_INT = 2'd0;
  localparam logic [1:0] SRC_LP_INT   = 2'd1;

  function automatic pmu_ctl_t ctl_for_mode(pmu_mode_e m);
    pmu_ctl_t c;
    c = '{core_halt: 1'b1, core_clk_en: 1'b0, periph_clk_en: 1'b0,
          osc_en: 1'b0, pwr_en: 1'b0, ret_en: 1'b0};
    unique case (m)
      PM_RUN: begin
        c.core_halt = 1'b0; c.core_clk_en = 1'b1; c.periph_clk_en = 1'b1;
        c.osc_en = 1'b1; c.pwr_en = 1'b1;
      end
      PM_IDLE: begin
        c.periph_clk_en = 1'b1; c.osc_en = 1'b1; c.pwr_en = 1'b1;
      end
      PM_SUSP:  c.pwr_en = 1'b1;
      PM_STOP:  c.ret_en = 1'b1;
      PM_SLEEP: c.ret_en = 1'b1;
      PM_WAKE: begin
        c.osc_en = 1'b1; c.pwr_en = 1'b1;
      end
      default: c.core_halt = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmu_req_arb.sv
module pmu_req_arb
  import pmu_pkg::*;
#(
  parameter int unsigned SRC_W = 2
) (
  input  logic                 in_run,
  input  logic                 req_we,
  input  logic [REQ_W-1:0]     req_bits,
  input  logic [SRC_W-1:0]     clk_src,
  output logic                 go,
  output pmu_mode_e            tgt,
  output logic                 src_bad
);

  localparam int unsigned NREQ = REQ_W;

  logic [NREQ-1:0] win;
  logic            src_ok;

  // one-hot winner: a bit wins if no deeper bit is set
  generate
    for (genvar g = 0; g < NREQ; g++) begin : g_prio
      if (g == NREQ - 1) begin : g_top
        assign win[g] = req_bits[g];
      end else begin : g_low
        assign win[g] = req_bits[g] & ~(|req_bits[NREQ-1:g+1]);
      end
    end
  endgenerate

  assign src_ok = (clk_src == SRC_W'(SRC_FAST_INT)) || (clk_src == SRC_W'(SRC_LP_INT));

  always_comb begin
    tgt = PM_RUN;
    if (win[REQ_STOP])       tgt = PM_STOP;
    else if (win[REQ_SLEEP]) tgt = PM_SLEEP;
    else if (win[REQ_SUSP])  tgt = PM_SUSP;
    else if (win[REQ_IDLE])  tgt = PM_IDLE;
  end

  assign src_bad = in_run & req_we & win[REQ_SUSP] & ~src_ok;
  assign go      = in_run & req_we & (|req_bits) & ~src_bad;

endmodule

// File: rtl/pmu_wake_qual.sv
module pmu_wake_qual #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wk_rtc_alarm,
  input  logic wk_rtc_fail,
  input  logic wk_touch,
  input  logic wk_port,
  input  logic cmp0_in,
  output logic cmp_rise,
  output logic susp_wake,
  output logic sleep_wake
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= cmp0_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign cmp_rise   = sync_q[LAST] & ~prev_q;
  assign sleep_wake = wk_rtc_alarm | wk_rtc_fail | wk_port | cmp_rise;
  assign susp_wake  = sleep_wake | wk_touch;

  // R9
  rise_needs_low_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rise |=> !cmp_rise);

endmodule

// File: rtl/pmu_fsm.sv
module pmu_fsm
  import pmu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  pmu_mode_e tgt,
  input  logic      src_bad,
  input  logic      irq_pend,
  input  logic      susp_wake,
  input  logic      sleep_wake,
  input  logic      osc_ready,
  output pmu_mode_e state,
  output logic      err
);

  pmu_mode_e state_q, state_d;
  logic      err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:   if (go)         state_d = tgt;
      PM_IDLE:  if (irq_pend)   state_d = PM_RUN;
      PM_SUSP:  if (susp_wake)  state_d = PM_WAKE;
      PM_SLEEP: if (sleep_wake) state_d = PM_WAKE;
      PM_STOP:                  state_d = PM_STOP;
      PM_WAKE:  if (osc_ready)  state_d = PM_RUN;
      default:                  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (src_bad) err_q <= 1'b1;
    end
  end

  assign state = state_q;
  assign err   = err_q;

  // R8
  stop_is_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP) |=> (state_q == PM_STOP));
  // R4
  idle_irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && irq_pend) |=> (state_q == PM_RUN));
  // R10
  wake_waits_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAKE && !osc_ready) |=> (state_q == PM_WAKE));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && !sleep_wake) |=> (state_q == PM_SLEEP));

endmodule

// File: rtl/pmu_seq_ctrl.sv
module pmu_seq_ctrl
  import pmu_pkg::*;
#(
  parameter int unsigned SRC_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_we,
  input  logic [3:0]       req_bits,
  input  logic [SRC_W-1:0] clk_src,
  input  logic             irq_pend,
  input  logic             wk_rtc_alarm,
  input  logic             wk_rtc_fail,
  input  logic             wk_touch,
  input  logic             wk_port,
  input  logic             cmp0_in,
  input  logic             osc_ready,
  output logic [2:0]       mode,
  output logic             core_halt,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             pwr_en,
  output logic             ret_en,
  output logic             clk_err
);

  pmu_mode_e state, tgt;
  logic      go, src_bad, cmp_rise, susp_wake, sleep_wake;
  pmu_ctl_t  ctl;

  pmu_req_arb #(.SRC_W(SRC_W)) u_arb (
    .in_run   (state == PM_RUN),
    .req_we   (req_we),
    .req_bits (req_bits),
    .clk_src  (clk_src),
    .go       (go),
    .tgt      (tgt),
    .src_bad  (src_bad)
  );

  pmu_wake_qual #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk          (clk),
    .rst_n        (rst_n),
    .wk_rtc_alarm (wk_rtc_alarm),
    .wk_rtc_fail  (wk_rtc_fail),
    .wk_touch     (wk_touch),
    .wk_port      (wk_port),
    .cmp0_in      (cmp0_in),
    .cmp_rise     (cmp_rise),
    .susp_wake    (susp_wake),
    .sleep_wake   (sleep_wake)
  );

  pmu_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .tgt        (tgt),
    .src_bad    (src_bad),
    .irq_pend   (irq_pend),
    .susp_wake  (susp_wake),
    .sleep_wake (sleep_wake),
    .osc_ready  (osc_ready),
    .state      (state),
    .err        (clk_err)
  );

  assign ctl           = ctl_for_mode(state);
  assign mode          = state;
  assign core_halt     = ctl.core_halt;
  assign core_clk_en   = ctl.core_clk_en;
  assign periph_clk_en = ctl.periph_clk_en;
  assign osc_en        = ctl.osc_en;
  assign pwr_en        = ctl.pwr_en;
  assign ret_en        = ctl.ret_en;

  // R2
  halted_core_unclocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt |-> !core_clk_en);
  // R6
  susp_leaves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SUSP && wk_touch) |=> (mode == 3'd5));

endmodule

// File: tb/test_pmu_seq_ctrl.sv
module test_pmu_seq_ctrl;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_we = 1'b0;
  logic [3:0] req_bits = '0;
  logic [1:0] clk_src = '0;
  logic irq_pend = 1'b0, wk_rtc_alarm = 1'b0, wk_rtc_fail = 1'b0;
  logic wk_touch = 1'b0, wk_port = 1'b0, cmp0_in = 1'b0, osc_ready = 1'b0;
  logic [2:0] mode;
  logic core_halt, core_clk_en, periph_clk_en, osc_en, pwr_en, ret_en, clk_err;

  int vectors = 0;
  int fails = 0;

  // bench model state
  logic [2:0] exp_mode = 3'd0;
  logic       exp_err = 1'b0;
  logic       m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_seq_ctrl i_pmu_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_bits(req_bits),
    .clk_src(clk_src), .irq_pend(irq_pend), .wk_rtc_alarm(wk_rtc_alarm),
    .wk_rtc_fail(wk_rtc_fail), .wk_touch(wk_touch), .wk_port(wk_port),
    .cmp0_in(cmp0_in), .osc_ready(osc_ready), .mode(mode),
    .core_halt(core_halt), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .pwr_en(pwr_en),
    .ret_en(ret_en), .clk_err(clk_err)
  );

  // R2 table: {halt, core, periph, osc, pwr, ret}
  function automatic logic [5:0] exp_ctl(logic [2:0] m);
    case (m)
      3'd0: return 6'b011110;
      3'd1: return 6'b101110;
      3'd2: return 6'b100010;
      3'd3: return 6'b100001;
      3'd4: return 6'b100001;
      default: return 6'b100110;
    endcase
  endfunction

  // R3 priority, R5 gating
  function automatic logic [2:0] req_target(logic [3:0] b);
    if (b[3]) return 3'd3;
    if (b[2]) return 3'd4;
    if (b[1]) return 3'd2;
    if (b[0]) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic [2:0] next_mode(logic [2:0] m, logic we, logic [3:0] b,
      logic [1:0] src, logic irq, logic al, logic fa, logic tc, logic pt,
      logic rise, logic rdy);
    logic [2:0] t;
    case (m)
      3'd0: begin
        t = req_target(b);
        if (!we || t == 3'd0) return 3'd0;
        if (t == 3'd2 && src > 2'd1) return 3'd0;
        return t;
      end
      3'd1: return irq ? 3'd0 : 3'd1;
      3'd2: return (al | fa | tc | pt | rise) ? 3'd5 : 3'd2;
      3'd4: return (al | fa | pt | rise) ? 3'd5 : 3'd4;
      3'd3: return 3'd3;
      default: return rdy ? 3'd0 : 3'd5;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R8";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag);
    logic [5:0] act;
    act = {core_halt, core_clk_en, periph_clk_en, osc_en, pwr_en, ret_en};
    vectors++;
    if (mode !== exp_mode || act !== exp_ctl(exp_mode) || clk_err !== exp_err) begin
      fails++;
      $display("FAIL %s: mode=%0d ctl=%b err=%b expected mode=%0d ctl=%b err=%b",
               tag, mode, act, clk_err, exp_mode, exp_ctl(exp_mode), exp_err);
    end
  endtask

  // called at a falling edge: drive, model the next rising edge, check at next falling edge
  task automatic step(string tag, logic we, logic [3:0] b, logic [1:0] src,
      logic irq, logic al, logic fa, logic tc, logic pt, logic cmp, logic rdy);
    logic rise;
    string t;
    req_we = we; req_bits = b; clk_src = src; irq_pend = irq;
    wk_rtc_alarm = al; wk_rtc_fail = fa; wk_touch = tc; wk_port = pt;
    cmp0_in = cmp; osc_ready = rdy;
    rise = m_s2 & ~m_s3;
    if (exp_mode == 3'd0 && we && req_target(b) == 3'd2 && src > 2'd1) exp_err = 1'b1;
    exp_mode = next_mode(exp_mode, we, b, src, irq, al, fa, tc, pt, rise, rdy);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cmp;
    t = (tag == "") ? tag_of(exp_mode) : tag;
    @(negedge clk);
    check(t);
  endtask

  task automatic idle_cycle(string tag, logic cmp);
    step(tag, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, cmp, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    exp_mode = 3'd0; exp_err = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
    check("R1");
    @(negedge clk);
    m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
    check("R1");
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R3: zero field and idle request
    step("R3", 1'b1, 4'h0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 1'b1, 4'h1, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    // R4: wake lines ignored in idle, irq exits
    step("R4", 1'b0, 4'h0, 2'd0, 0, 1, 1, 1, 1, 0, 1);
    step("R4", 1'b0, 4'h0, 2'd0, 1, 0, 0, 0, 0, 0, 0);
    // R5: suspend under low-frequency source is refused, error sticks
    step("R5", 1'b1, 4'h2, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1'b1, 4'h2, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1'b1, 4'h2, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    // R6: irq ignored in suspend, touch wakes
    step("R6", 1'b0, 4'h0, 2'd1, 1, 0, 0, 0, 0, 0, 0);
    step("R6", 1'b0, 4'h0, 2'd1, 0, 0, 0, 1, 0, 0, 0);
    // R10: wait for oscillator
    for (int i = 0; i < 3; i++) idle_cycle("R10", 1'b0);
    step("R10", 1'b0, 4'h0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
    do_reset();
    // R3: priority sleep over suspend and idle (bad src, no error since sleep wins)
    step("R3", 1'b1, 4'h7, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    // R7: touch ignored in sleep, port wakes
    step("R7", 1'b0, 4'h0, 2'd0, 0, 0, 0, 1, 0, 0, 0);
    step("R7", 1'b0, 4'h0, 2'd0, 0, 0, 0, 0, 1, 0, 0);
    step("R10", 1'b0, 4'h0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
    // R9: comparator high before entry does not wake
    for (int i = 0; i < 4; i++) idle_cycle("R9", 1'b1);
    step("R9", 1'b1, 4'h2, 2'd0, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) idle_cycle("R9", 1'b1);
    for (int i = 0; i < 3; i++) idle_cycle("R9", 1'b0);
    for (int i = 0; i < 3; i++) idle_cycle("R9", 1'b1);
    step("R10", 1'b0, 4'h0, 2'd0, 0, 0, 0, 0, 0, 1, 1);
    // R8: stop wins and holds against everything
    step("R8", 1'b1, 4'hF, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R8", 1'b1, 4'h1, 2'd0, 1, 1, 1, 1, 1, i[0], 1);
    do_reset();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic we, irq, al, fa, tc, pt, cmp, rdy;
      logic [3:0] b;
      logic [1:0] src;
      if (exp_mode == 3'd3 && ($urandom % 8) == 0) begin
        do_reset();
      end else begin
        we  = ($urandom % 6) == 0;
        b   = 4'($urandom);
        if (($urandom % 3) != 0) b = b & 4'h3;
        src = 2'($urandom);
        irq = ($urandom % 10) == 0;
        al  = ($urandom % 25) == 0;
        fa  = ($urandom % 25) == 0;
        tc  = ($urandom % 15) == 0;
        pt  = ($urandom % 20) == 0;
        cmp = (($urandom % 12) == 0) ? ~cmp0_in : cmp0_in;
        rdy = ($urandom % 3) == 0;
        step("", we, b, src, irq, al, fa, tc, pt, cmp, rdy);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule